// File: doc/BRIEF.md
# Video Frame Timing and Vertical-Blank Generator

This block keeps the raster position of a 262-line video frame and produces the vertical-blank status flag and the interrupt request that software uses to synchronise with the display. A dot enable advances the position by one dot. In the intended system this enable pulses three times per processor cycle. Each line has 341 dots. Lines are numbered from -1 (the pre-render line) up to 260, and after line 260 the count returns to -1.

The blank flag is not set or cleared at the moment the raster reaches the event dot. A small signed countdown is loaded first: +2 at the start of line 241 and -5 at the start of the pre-render line. It moves one step toward zero on each dot. The flag is set when the countdown is at +2 and the status byte is cleared when it is at -5. The interrupt output is resampled only while the countdown rests at zero. A status read returns the byte and clears the flag. The read also cancels a pending set, unless the clear countdown has just been loaded. On every second frame, when rendering is enabled, the pre-render line is one dot short. This choice is made at dot 338 of that line.

Top module: `frame_timing_gen`

## Requirements
- R1: Each dot enable advances dot_o by one. A line has dots 0 to 340, and after dot 340 the next line starts at dot 0. line_o is two's complement and counts -1, 0, ..., 260, then returns to -1.
- R2: Status bit 7 (vertical blank) reads 0 at position (241,1) and 1 at (241,2). Bits 6:0 of stat_o always read 0.
- R3: With the flag set, stat_o reads 0x80 at position (-1,1) and 0x00 at (-1,2).
- R4: nmi_o is registered. It takes the value (interrupt enable AND status bit 7) only on dots where the countdown is zero, and it holds on every other cycle. With the enable set it rises at (241,4), and it falls at (-1,7).
- R5: A frame toggle flips at dot 0 of line -1. When the toggle is 1 at dot 338 of line -1 and the render enable is set, that line ends after dot 339. Otherwise it ends after dot 340.
- R6: stat_o shows the current status combinationally in the cycle of the read strobe. After that clock edge bit 7 reads 0.
- R7: A read cancels a pending set, so no set follows in that frame. A read in the cycle in which the clear countdown is at -5 does not cancel that countdown, so nmi_o still stays 1 until (-1,7).
- R8: In a cycle without a dot enable, the position, the status and nmi_o do not change, apart from the effect of a read.
- R9: The active-low reset puts the position at (241,0). It clears the status, nmi_o, the enables, the toggle and the countdown.
- R10: The interrupt enable and the render enable are loaded from their data inputs on the clock edge at which their write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dot_en_i | input | 1 | Advance the raster by one dot |
| ctrl_we_i | input | 1 | Write strobe for the interrupt enable |
| nmi_en_i | input | 1 | Interrupt enable value |
| mask_we_i | input | 1 | Write strobe for the render enable |
| render_en_i | input | 1 | Render enable value (allows the short line) |
| stat_rd_i | input | 1 | Status read strobe |
| stat_o | output | 8 | Status byte, bit 7 = vertical blank |
| nmi_o | output | 1 | Interrupt request level |
| line_o | output | 10 | Current line, two's complement |
| dot_o | output | 9 | Current dot |

## Verification
If the countdown held a wrong value, the flag edges would move away from dots (241,2) and (-1,2). The interrupt edge would also leave (241,4) or (-1,7) within a few dots, and a wrongly applied cancel would suppress the whole blank period of that frame. An error in the frame toggle or in the short-line decision shows only at the end of the pre-render line, as a missing or extra dot 340. Wrap errors show as a wrong line number at the first line boundary after the error.

// File: rtl/frame_pkg.sv
package frame_pkg;
  parameter int LINE_W = 10;
  parameter int DOT_W  = 9;
  parameter int CNT_W  = 4;
  parameter int STAT_W = 8;
  typedef logic signed [LINE_W-1:0] line_t;
  typedef logic [DOT_W-1:0]         dot_t;
  typedef logic signed [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/frame_raster.sv
module frame_raster
  import frame_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LAST_LINE = 260,
  parameter int VBL_LINE  = 241,
  parameter int SHORT_DOT = 338
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  skip_en_i,
  output dot_t  dot_o,
  output line_t line_o,
  output logic  vbl_start_o,
  output logic  pre_start_o
);
  localparam line_t PRE_LINE = line_t'(-1);
  localparam dot_t  END_LONG  = dot_t'(DOTS - 1);
  localparam dot_t  END_SHORT = dot_t'(DOTS - 2);

  dot_t  dot_q;
  line_t line_q;
  logic  odd_q, short_q;
  logic  is_pre, line_end;

  assign is_pre   = (line_q == PRE_LINE);
  assign line_end = (dot_q == (short_q ? END_SHORT : END_LONG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q   <= '0;
      line_q  <= line_t'(VBL_LINE);
      odd_q   <= 1'b0;
      short_q <= 1'b0;
    end else if (tick_i) begin
      if (is_pre && dot_q == '0) odd_q <= ~odd_q;
      if (line_end) begin
        dot_q   <= '0;
        short_q <= 1'b0;
        line_q  <= (line_q == line_t'(LAST_LINE)) ? PRE_LINE : line_q + line_t'(1);
      end else begin
        dot_q <= dot_q + dot_t'(1);
        if (is_pre && dot_q == dot_t'(SHORT_DOT) && skip_en_i && odd_q) short_q <= 1'b1;
      end
    end
  end

  assign dot_o       = dot_q;
  assign line_o      = line_q;
  assign vbl_start_o = tick_i && dot_q == '0 && line_q == line_t'(VBL_LINE);
  assign pre_start_o = tick_i && dot_q == '0 && is_pre;

  AST_DOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_q <= END_LONG); // R1
  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && line_q == line_t'(LAST_LINE) && dot_q == END_LONG |=> line_q == PRE_LINE && dot_q == '0); // R1
  AST_SHORT_ONLY_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_q |-> is_pre && dot_q > dot_t'(SHORT_DOT)); // R5
  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(dot_q) && $stable(line_q)); // R8
endmodule

// File: rtl/vblank_seq.sv
module vblank_seq
  import frame_pkg::*;
#(
  parameter int SET_DLY = 2,
  parameter int CLR_DLY = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic set_start_i,
  input  logic clr_start_i,
  input  logic rd_i,
  input  logic nmi_en_i,
  output logic vbl_o,
  output logic nmi_o
);
  localparam cnt_t SET_V = cnt_t'(SET_DLY);
  localparam cnt_t CLR_V = cnt_t'(-CLR_DLY);

  cnt_t cnt_q, cnt_step, cnt_tick, cnt_d;
  logic vbl_q, vbl_d, nmi_q;

  always_comb begin
    if (cnt_q == '0)            cnt_step = '0;
    else if (cnt_q[CNT_W-1])    cnt_step = cnt_q + cnt_t'(1);
    else                        cnt_step = cnt_q - cnt_t'(1);
    cnt_tick = cnt_q;
    if (tick_i) begin
      if (set_start_i)      cnt_tick = SET_V;
      else if (clr_start_i) cnt_tick = CLR_V;
      else                  cnt_tick = cnt_step;
    end
    // read after the dot step; pending clear survives
    cnt_d = (rd_i && cnt_tick != CLR_V) ? '0 : cnt_tick;
  end

  always_comb begin
    vbl_d = vbl_q;
    if (tick_i) begin
      if (cnt_q == CLR_V)      vbl_d = 1'b0;
      else if (cnt_q == SET_V) vbl_d = 1'b1;
    end
    if (rd_i) vbl_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vbl_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vbl_q <= vbl_d;
      if (tick_i && cnt_q == '0) nmi_q <= nmi_en_i & vbl_q;
    end
  end

  assign vbl_o = vbl_q;
  assign nmi_o = nmi_q;

  AST_SET_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_q == SET_V && !rd_i |=> vbl_q); // R2
  AST_CLR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_q == CLR_V |=> !vbl_q); // R3
  AST_NMI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && cnt_q == '0) |=> $stable(nmi_q)); // R4
  AST_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !vbl_q); // R6
  AST_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !tick_i && cnt_q != CLR_V |=> cnt_q == '0); // R7
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import frame_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LAST_LINE = 260,
  parameter int VBL_LINE  = 241,
  parameter int SHORT_DOT = 338,
  parameter int SET_DLY   = 2,
  parameter int CLR_DLY   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dot_en_i,
  input  logic              ctrl_we_i,
  input  logic              nmi_en_i,
  input  logic              mask_we_i,
  input  logic              render_en_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              nmi_o,
  output logic [LINE_W-1:0] line_o,
  output logic [DOT_W-1:0]  dot_o
);
  logic  nmi_en_q, render_en_q;
  logic  vbl_start, pre_start, vbl;
  line_t line_w;
  dot_t  dot_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_en_q    <= 1'b0;
      render_en_q <= 1'b0;
    end else begin
      if (ctrl_we_i) nmi_en_q    <= nmi_en_i;
      if (mask_we_i) render_en_q <= render_en_i;
    end
  end

  frame_raster #(
    .DOTS(DOTS), .LAST_LINE(LAST_LINE), .VBL_LINE(VBL_LINE), .SHORT_DOT(SHORT_DOT)
  ) u_raster (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(dot_en_i), .skip_en_i(render_en_q),
    .dot_o(dot_w), .line_o(line_w), .vbl_start_o(vbl_start), .pre_start_o(pre_start)
  );

  vblank_seq #(.SET_DLY(SET_DLY), .CLR_DLY(CLR_DLY)) u_vbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(dot_en_i), .set_start_i(vbl_start),
    .clr_start_i(pre_start), .rd_i(stat_rd_i), .nmi_en_i(nmi_en_q),
    .vbl_o(vbl), .nmi_o(nmi_o)
  );

  assign stat_o = {vbl, {(STAT_W-1){1'b0}}};
  assign line_o = line_w;
  assign dot_o  = dot_w;

  AST_NMI_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> $past(vbl) && $past(nmi_en_q)); // R4
endmodule

// File: tb/frame_timing_gen_tb.sv
module frame_timing_gen_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dot_en = 1'b0, ctrl_we = 1'b0, nmi_en = 1'b0, mask_we = 1'b0, render_en = 1'b0, rd = 1'b0;
  logic [7:0] stat;
  logic nmi;
  logic signed [9:0] line;
  logic [8:0] dot;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  frame_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dot_en_i(dot_en), .ctrl_we_i(ctrl_we), .nmi_en_i(nmi_en),
    .mask_we_i(mask_we), .render_en_i(render_en), .stat_rd_i(rd),
    .stat_o(stat), .nmi_o(nmi), .line_o(line), .dot_o(dot)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic goto_pos(input logic signed [9:0] l, input int d);
    while (!(line == l && int'(dot) == d)) begin
      dot_en = 1'b1;
      @(negedge clk);
    end
    dot_en = 1'b0;
  endtask

  task automatic step();
    dot_en = 1'b1;
    @(negedge clk);
    dot_en = 1'b0;
  endtask

  task automatic wr_ctrl(input logic v);
    ctrl_we = 1'b1; nmi_en = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_mask(input logic v);
    mask_we = 1'b1; render_en = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] seen);
    rd = 1'b1;
    #1 seen = stat;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R9 line", int'(line), 241);
    chk("R9 dot", int'(dot), 0);
    chk("R9 stat", int'(stat), 0);
    chk("R9 nmi", int'(nmi), 0);
  endtask

  task automatic t_hold();
    repeat (4) @(negedge clk);
    chk("R8 dot held", int'(dot), 0);
    chk("R8 line held", int'(line), 241);
    chk("R8 stat held", int'(stat), 0);
  endtask

  task automatic t_vbl_set();
    goto_pos(10'sd241, 1);
    chk("R2 before set", int'(stat), 0);
    goto_pos(10'sd241, 2);
    chk("R2 set", int'(stat), 8'h80);
    goto_pos(10'sd241, 3);
    chk("R4 nmi low", int'(nmi), 0);
    goto_pos(10'sd241, 4);
    chk("R4 nmi rise", int'(nmi), 1);
  endtask

  task automatic t_ctrl_write();
    goto_pos(10'sd245, 0);
    wr_ctrl(1'b0);
    chk("R4 nmi holds without dot", int'(nmi), 1);
    step();
    chk("R10 enable off drops nmi", int'(nmi), 0);
    wr_ctrl(1'b1);
    step();
    chk("R10 enable on raises nmi", int'(nmi), 1);
  endtask

  task automatic t_clear();
    goto_pos(-10'sd1, 1);
    chk("R3 before clear", int'(stat), 8'h80);
    goto_pos(-10'sd1, 2);
    chk("R3 cleared", int'(stat), 0);
    goto_pos(-10'sd1, 6);
    chk("R4 nmi still high", int'(nmi), 1);
    goto_pos(-10'sd1, 7);
    chk("R4 nmi fall", int'(nmi), 0);
  endtask

  task automatic t_short_line();
    goto_pos(-10'sd1, 339);
    step();
    chk("R5 short line next line", int'(line), 0);
    chk("R5 short line next dot", int'(dot), 0);
  endtask

  task automatic t_cancel();
    logic [7:0] seen;
    goto_pos(10'sd241, 1);
    rd_stat(seen);
    chk("R6 read value", int'(seen), 0);
    goto_pos(10'sd241, 5);
    chk("R7 set cancelled", int'(stat), 0);
    chk("R7 no nmi", int'(nmi), 0);
  endtask

  task automatic t_wrap();
    goto_pos(10'sd260, 340);
    step();
    chk("R1 wrap line", int'(line), -1);
    chk("R1 wrap dot", int'(dot), 0);
    goto_pos(-10'sd1, 339);
    step();
    chk("R5 even frame long line", int'(dot), 340);
    step();
    chk("R1 line after dot 340", int'(line), 0);
  endtask

  task automatic t_read_during_clear();
    logic [7:0] seen;
    t_reset_state();
    wr_ctrl(1'b1);
    goto_pos(10'sd241, 4);
    chk("R4 nmi rise run3", int'(nmi), 1);
    goto_pos(-10'sd1, 1);
    rd_stat(seen);
    chk("R6 read shows flag", int'(seen), 8'h80);
    chk("R6 flag cleared by read", int'(stat), 0);
    goto_pos(-10'sd1, 6);
    chk("R7 clear not cancelled", int'(nmi), 1);
    goto_pos(-10'sd1, 7);
    chk("R7 nmi falls on time", int'(nmi), 0);
    goto_pos(-10'sd1, 339);
    step();
    chk("R5 render off long line", int'(dot), 340);
    step();
    chk("R5 render off next line", int'(line), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    wr_ctrl(1'b1);
    wr_mask(1'b1);
    chk("R10 write does not move dot", int'(dot), 0);
    t_hold();
    t_vbl_set();
    t_ctrl_write();
    t_clear();
    t_short_line();
    t_cancel();
    t_wrap();
    t_read_during_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule